// File: doc/BRIEF.md
# BCD Real-Time Clock with Snapshot Registers

This block keeps time of day and a calendar as packed BCD counters that advance once per pulse on a one-second tick input. Software never reads those counters directly. It reads eight byte-wide visible registers on a simple synchronous bus. Each time the counters advance, the block copies every field into the visible registers in a single clock cycle. A read bit in the control byte stops that copy, so software can read a set of fields that belong together while the counters keep running underneath.

A write bit opens the visible registers to the bus so software can set the time. Clearing the write bit moves the whole visible set into the counters at once. A stop bit inside the seconds byte makes the counters ignore ticks. The control byte also stores a signed calibration value for software to read back. That value has no effect on counting.

Top module: `rtc_shadow_core`

## Requirements
- R1: The eight registers occupy the top eight byte addresses of the `ADDR_W`-bit space. Offset 0 is control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. A read strobe returns the addressed byte on `rdata` one clock later. A read outside the window returns 0x00.
- R2: Seconds count from 00 to 59 and minutes from 00 to 59, both in BCD. Hours count from 00 to 23 in 24-hour form. Each field carries into the next field when it wraps.
- R3: At midnight the date advances within the month's length: 30 days for 04, 06, 09 and 11, and 28 days for 02, or 29 days when the BCD year is a multiple of four. Every other month has 31 days. Month 12 wraps to 01 and carries into the year, which wraps from 99 to 00. The day of week advances from 01 to 07 and wraps back to 01.
- R4: The control byte holds write = D7, read = D6, calibration sign = D5 and magnitude = D4..D0. The stop bit is seconds D7 and the frequency-test bit is day D6. These two bits accept a write at any time. Bits with no field read as 0: minutes D7, hours D7..D6, day D5..D3, date D7..D6 and month D7..D5.
- R5: While the read bit is 1, ticks do not change the visible time registers. The counters keep advancing during that time.
- R6: One clock after a tick, all seven visible time fields take the new counter values together, in the same clock.
- R7: If the read bit is written to 1 in the same clock as a pending copy, the copy still completes.
- R8: Clearing the read bit does not refresh the visible registers by itself. The next tick brings them up to the running count.
- R9: While the write bit is 1, bus writes land in the visible time fields and copies from the counters are suppressed. Writing the write bit back to 0 loads every counter from the visible fields in that same clock.
- R10: While the stop bit is 1, ticks are ignored and the counters hold. Clearing the stop bit resumes counting from the held value.
- R11: After reset, the registers read 00:00:00, day 01, date 01, month 01, year 00, and control 0x00.
- R12: The calibration sign and magnitude read back as written and do not change how ticks advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
Single ticks from a small count check plain BCD increments. Preloaded end-of-period times (the last second of February in a leap year and in a common year, of a 30-day month, and of the year) separate the carry chain from the month-length table and the weekday wrap. Ticks sent while the read bit is set, followed by a read right after the bit clears and another after the next tick, show whether the snapshot froze, whether it refreshed too early, and whether the counters kept running underneath. Ticks sent under the stop bit, under the write bit and with a nonzero calibration value each show whether the counters advanced, held or were loaded from the visible registers.

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata
);

  localparam logic [2:0] O_CTRL = 3'd0, O_SEC = 3'd1, O_MIN = 3'd2, O_HR = 3'd3,
                         O_WDAY = 3'd4, O_MDAY = 3'd5, O_MON = 3'd6, O_YR = 3'd7;

  wire       in_win = &addr[ADDR_W-1:3];
  wire [2:0] sel    = addr[2:0];
  wire       wr_hit = wr_en && in_win;

  logic [6:0] c_sec, c_min, s_sec, s_min;
  logic [5:0] c_hr, c_mday, s_hr, s_mday;
  logic [2:0] c_wday, s_wday;
  logic [4:0] c_mon, s_mon;
  logic [7:0] c_yr, s_yr;
  logic       stop_q, ft_q, wbit_q, rbit_q, cal_sign_q, pend_q;
  logic [4:0] cal_mag_q;

  wire load = wr_hit && sel == O_CTRL && wbit_q && !wdata[7];
  wire adv  = tick && !stop_q;
  wire copy = pend_q && !rbit_q && !wbit_q;

  wire leap = c_yr[4] ? (c_yr[3:0] == 4'h2 || c_yr[3:0] == 4'h6)
                      : (c_yr[3:0] == 4'h0 || c_yr[3:0] == 4'h4 || c_yr[3:0] == 4'h8);
  logic [5:0] mlen;
  always_comb begin
    case (c_mon)
      5'h02:                      mlen = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: mlen = 6'h30;
      default:                    mlen = 6'h31;
    endcase
  end

  wire sec_cy  = c_sec >= 7'h59;
  wire min_cy  = sec_cy && c_min >= 7'h59;
  wire hr_cy   = min_cy && c_hr >= 6'h23;
  wire mday_cy = hr_cy && c_mday >= mlen;
  wire mon_cy  = mday_cy && c_mon >= 5'h12;

  wire [6:0] n_sec  = (c_sec[3:0] == 4'h9)  ? {c_sec[6:4] + 3'd1, 4'h0}  : c_sec + 7'd1;
  wire [6:0] n_min  = (c_min[3:0] == 4'h9)  ? {c_min[6:4] + 3'd1, 4'h0}  : c_min + 7'd1;
  wire [5:0] n_hr   = (c_hr[3:0] == 4'h9)   ? {c_hr[5:4] + 2'd1, 4'h0}   : c_hr + 6'd1;
  wire [5:0] n_mday = (c_mday[3:0] == 4'h9) ? {c_mday[5:4] + 2'd1, 4'h0} : c_mday + 6'd1;
  wire [4:0] n_mon  = (c_mon[3:0] == 4'h9)  ? {c_mon[4] + 1'b1, 4'h0}    : c_mon + 5'd1;
  wire [7:0] n_yr   = (c_yr[3:0] == 4'h9)   ? {c_yr[7:4] + 4'd1, 4'h0}   : c_yr + 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sec <= '0; c_min <= '0; c_hr <= '0; c_wday <= 3'd1;
      c_mday <= 6'h01; c_mon <= 5'h01; c_yr <= '0;
    end else if (load) begin
      c_sec <= s_sec; c_min <= s_min; c_hr <= s_hr; c_wday <= s_wday;
      c_mday <= s_mday; c_mon <= s_mon; c_yr <= s_yr;
    end else if (adv) begin
      c_sec <= sec_cy ? 7'h00 : n_sec;
      if (sec_cy)  c_min <= (c_min >= 7'h59) ? 7'h00 : n_min;
      if (min_cy)  c_hr  <= (c_hr >= 6'h23) ? 6'h00 : n_hr;
      if (hr_cy) begin
        c_wday <= (c_wday >= 3'd7) ? 3'd1 : c_wday + 3'd1;
        c_mday <= mday_cy ? 6'h01 : n_mday;
      end
      if (mday_cy) c_mon <= mon_cy ? 5'h01 : n_mon;
      if (mon_cy)  c_yr  <= (c_yr >= 8'h99) ? 8'h00 : n_yr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= adv && !load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sec <= '0; s_min <= '0; s_hr <= '0; s_wday <= 3'd1;
      s_mday <= 6'h01; s_mon <= 5'h01; s_yr <= '0;
    end else if (copy) begin
      s_sec <= c_sec; s_min <= c_min; s_hr <= c_hr; s_wday <= c_wday;
      s_mday <= c_mday; s_mon <= c_mon; s_yr <= c_yr;
    end else if (wr_hit && wbit_q) begin
      case (sel)
        O_SEC:   s_sec  <= wdata[6:0];
        O_MIN:   s_min  <= wdata[6:0];
        O_HR:    s_hr   <= wdata[5:0];
        O_WDAY:  s_wday <= wdata[2:0];
        O_MDAY:  s_mday <= wdata[5:0];
        O_MON:   s_mon  <= wdata[4:0];
        O_YR:    s_yr   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbit_q <= 1'b0; rbit_q <= 1'b0; cal_sign_q <= 1'b0; cal_mag_q <= '0;
      stop_q <= 1'b0; ft_q <= 1'b0;
    end else if (wr_hit) begin
      if (sel == O_CTRL) begin
        wbit_q <= wdata[7]; rbit_q <= wdata[6];
        cal_sign_q <= wdata[5]; cal_mag_q <= wdata[4:0];
      end
      if (sel == O_SEC)  stop_q <= wdata[7];
      if (sel == O_WDAY) ft_q   <= wdata[6];
    end
  end

  logic [7:0] rmux;
  always_comb begin
    case (sel)
      O_CTRL:  rmux = {wbit_q, rbit_q, cal_sign_q, cal_mag_q};
      O_SEC:   rmux = {stop_q, s_sec};
      O_MIN:   rmux = {1'b0, s_min};
      O_HR:    rmux = {2'b0, s_hr};
      O_WDAY:  rmux = {1'b0, ft_q, 3'b0, s_wday};
      O_MDAY:  rmux = {2'b0, s_mday};
      O_MON:   rmux = {3'b0, s_mon};
      default: rmux = s_yr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= in_win ? rmux : 8'h00;
  end

  AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (rbit_q && $past(rbit_q) && !$past(wbit_q)) |->
      $stable({s_sec, s_min, s_hr, s_wday, s_mday, s_mon, s_yr}));

  AST_ALL_FIELDS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (!$stable(s_sec) && !$past(wr_en && wbit_q)) |->
      ({s_sec, s_min, s_hr, s_wday, s_mday, s_mon, s_yr} ==
       $past({c_sec, c_min, c_hr, c_wday, c_mday, c_mon, c_yr})));

  AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) // R10
    ($past(stop_q) && !$past(load)) |->
      $stable({c_sec, c_min, c_hr, c_wday, c_mday, c_mon, c_yr}));

  AST_LOAD_IN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) // R9
    $past(load) |->
      ({c_sec, c_min, c_hr, c_wday, c_mday, c_mon, c_yr} ==
       {s_sec, s_min, s_hr, s_wday, s_mday, s_mon, s_yr}));

  AST_MONTH_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) // R4
    ($past(rd_en) && $past(addr[2:0]) == O_MON) |-> rdata[7:5] == 3'b000);

endmodule

// File: tb/rtc_shadow_core_test.sv
module rtc_shadow_core_test;
  localparam int AW = 15;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  wire  [7:0]    rdata;

  always #2 clk = ~clk;

  rtc_shadow_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  typedef struct {
    logic [7:0]    exp;
    string         tag;
    logic [AW-1:0] a;
  } item_t;

  item_t sb[$];
  int    checks = 0, fails = 0;
  logic  rd_q = 1'b0;
  bit    done = 1'b0;

  function automatic logic [AW-1:0] ra(int k);
    return {{(AW-3){1'b1}}, 3'(k)};
  endfunction

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
      end
    end
  end

  task automatic wr(int k, logic [7:0] d);
    addr = ra(k); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_at(logic [AW-1:0] a, logic [7:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag; it.a = a;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(int k, logic [7:0] e, string tag);
    rd_at(ra(k), e, tag);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    wr(0, 8'h80);
    wr(1, s); wr(2, m); wr(3, h); wr(4, wd); wr(5, dt); wr(6, mo); wr(7, y);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R1 map
    rd(0, 8'h00, "R11 ctrl"); rd(1, 8'h00, "R11 sec"); rd(2, 8'h00, "R11 min");
    rd(3, 8'h00, "R11 hr");   rd(4, 8'h01, "R11 wday"); rd(5, 8'h01, "R11 date");
    rd(6, 8'h01, "R11 month"); rd(7, 8'h00, "R11 year");
    rd_at('0, 8'h00, "R1 outside window");

    // R2 plain counting
    pulse(3);
    rd(1, 8'h03, "R2 sec after 3 ticks");

    // R9 write mode
    wr(0, 8'h80);
    rd(0, 8'h80, "R9 write bit readback");
    wr(1, 8'h58); wr(2, 8'h59); wr(3, 8'h23); wr(4, 8'h07);
    wr(5, 8'h28); wr(6, 8'h02); wr(7, 8'h23);
    rd(1, 8'h58, "R9 write lands");
    pulse(1);
    rd(1, 8'h58, "R9 copy suppressed");
    wr(0, 8'h00);
    pulse(1);
    rd(1, 8'h59, "R9 counters loaded");
    pulse(1);
    // R2/R3 full carry, common-year February, R6 all fields
    rd(1, 8'h00, "R2 sec wrap"); rd(2, 8'h00, "R2 min wrap"); rd(3, 8'h00, "R2 hr wrap");
    rd(4, 8'h01, "R3 wday wrap"); rd(5, 8'h01, "R3 feb 28 days"); rd(6, 8'h03, "R6 month");
    rd(7, 8'h23, "R6 year");

    // R3 leap February
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    pulse(1);
    rd(5, 8'h29, "R3 leap feb 29"); rd(6, 8'h02, "R3 leap month"); rd(4, 8'h04, "R3 wday");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    pulse(1);
    rd(5, 8'h01, "R3 leap end date"); rd(6, 8'h03, "R3 leap end month");

    // R3 30-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h25);
    pulse(1);
    rd(5, 8'h01, "R3 apr end date"); rd(6, 8'h05, "R3 apr end month"); rd(4, 8'h01, "R3 wday 7 to 1");

    // R3 year wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
    pulse(1);
    rd(7, 8'h00, "R3 year wrap"); rd(6, 8'h01, "R3 month wrap"); rd(5, 8'h01, "R3 date wrap");

    // R4 reserved bits and frequency-test bit
    wr(0, 8'h80);
    wr(4, 8'hC5); rd(4, 8'h45, "R4 day reserved/ft");
    wr(6, 8'hF2); rd(6, 8'h12, "R4 month reserved");
    wr(3, 8'hE3); rd(3, 8'h23, "R4 hour reserved");
    wr(2, 8'hA7); rd(2, 8'h27, "R4 minute reserved");
    wr(4, 8'h03);
    wr(0, 8'h00);

    // R10 stop bit
    wr(1, 8'h80);
    rd(1, 8'h80, "R10 stop readback, field untouched");
    pulse(3);
    rd(1, 8'h80, "R10 ticks ignored");
    wr(1, 8'h00);
    pulse(1);
    rd(1, 8'h01, "R10 resumes from held count");

    // R12 calibration
    wr(0, 8'h3F);
    rd(0, 8'h3F, "R12 calibration readback");
    pulse(1);
    rd(1, 8'h02, "R12 no effect on count");
    wr(0, 8'h00);

    // R7 halt during pending copy
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wr(0, 8'h40);
    rd(1, 8'h03, "R7 pending copy completes");
    rd(0, 8'h40, "R4 read bit position");
    pulse(4);
    rd(1, 8'h03, "R5 snapshot frozen");
    rd(2, 8'h27, "R5 minute frozen");
    wr(0, 8'h00);
    rd(1, 8'h03, "R8 no refresh before tick");
    pulse(1);
    rd(1, 8'h08, "R8 refresh shows running count");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard residue actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule